// File: doc/BRIEF.md
# Four-Way Age-Counter LRU Tracker

This block keeps least-recently-used order for an array of four-way cache sets. Each way of each set holds a 2-bit age, where 0 is the most recent and 3 is the oldest. It also holds an occupancy bit. A cache controller selects a set with `set_i`. It reports a hit on an occupied way with `hit_i`/`hit_way_i`, and it signals a miss fill with `fill_i`. The tracker chooses the way that the fill lands in and updates all ages of that set on the next clock edge.

The way to fill is offered combinationally on `victim_o` for the selected set. In a set that still has room, it is the lowest-numbered empty way. In a full set, it is the way whose age is 3. The ages and occupancy of the selected set are visible on the outputs, so the controller can inspect the ordering. Tag storage, data storage and hit/miss detection live outside this block.

Top module: `lru_age_tracker`

## Requirements
- R1: After the active-low asynchronous reset, every way of every set is unoccupied with age 0, `full_o` is 0 and `victim_o` is 0.
- R2: A hit on an occupied way sets that way's age to 0. Occupied ways whose age was below the hit way's old age increase by 1. All other ages stay the same.
- R3: A hit on an unoccupied way leaves the ages and occupancy of the set unchanged.
- R4: A fill into a set that is not full marks the lowest-numbered unoccupied way occupied with age 0. It increments every other occupied way and leaves the ages of unoccupied ways at 0.
- R5: A fill into a full set replaces the way whose age is 3, sets that way to age 0 and increments the other three ways.
- R6: `victim_o` is the lowest-numbered unoccupied way when `full_o` is 0. When `full_o` is 1 (all four ways occupied), `victim_o` is the way whose age is 3.
- R7: Occupied ways of a set always hold pairwise distinct ages.
- R8: When `hit_i` and `fill_i` are both high, the hit is applied and the fill is dropped, so occupancy does not change.
- R9: Only the set chosen by `set_i` is updated. The outputs always report the set chosen by `set_i`, with way w's age on `ages_o[2w+1:2w]` and its occupancy on `occ_o[w]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | IDX_W | Index of the set being accessed |
| hit_i | input | 1 | Hit strobe |
| hit_way_i | input | 2 | Way that hit |
| fill_i | input | 1 | Miss fill strobe |
| victim_o | output | 2 | Way the next fill uses in the selected set |
| full_o | output | 1 | All ways of the selected set are occupied |
| occ_o | output | 4 | Occupancy of each way of the selected set |
| ages_o | output | 8 | Ages of the selected set, 2 bits per way |

## Verification
The assertions check these behaviours on every cycle:
- occupied ways hold distinct ages;
- a hit on an occupied way makes it the youngest;
- a filled way becomes occupied at age 0;
- a full-set victim carries age 3;
- a hit on an empty way freezes the set;
- a simultaneous hit and fill leaves the occupied count unchanged.

Only the bench scenarios can show that the ages of the other ways move exactly as a move-to-front ordering would predict. The same holds for whether untouched sets keep their state and whether reset clears every set, so the bench compares each operation against a recency-list model.

// File: rtl/lru_pkg.sv
package lru_pkg;
  parameter int unsigned WAYS = 4;
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned AGE_W = WAY_W;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [AGE_W-1:0] age_t;
  typedef age_t [WAYS-1:0]  age_vec_t;
  typedef logic [WAYS-1:0]  occ_t;

  localparam age_t AGE_OLDEST = age_t'(WAYS - 1);
endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
  import lru_pkg::*;
(
  input  age_vec_t ages_i,
  input  occ_t     occ_i,
  output way_t     way_o,
  output logic     full_o
);
  logic found;

  always_comb begin
    full_o = &occ_i;
    way_o  = '0;
    found  = 1'b0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (!found) begin
        if (!full_o && !occ_i[w]) begin
          way_o = way_t'(w);
          found = 1'b1;
        end else if (full_o && ages_i[w] == AGE_OLDEST) begin
          way_o = way_t'(w);
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lru_age_next.sv
module lru_age_next
  import lru_pkg::*;
(
  input  age_vec_t ages_i,
  input  occ_t     occ_i,
  input  logic     hit_i,
  input  way_t     hit_way_i,
  input  logic     fill_i,
  input  way_t     fill_way_i,
  output age_vec_t ages_o,
  output occ_t     occ_o
);
  age_t ref_age;

  always_comb begin
    ages_o  = ages_i;
    occ_o   = occ_i;
    ref_age = ages_i[hit_way_i];
    if (hit_i) begin
      // hit wins over a concurrent fill; a hit on an empty way is dropped
      if (occ_i[hit_way_i]) begin
        for (int w = 0; w < int'(WAYS); w++) begin
          if (way_t'(w) == hit_way_i)
            ages_o[w] = '0;
          else if (occ_i[w] && ages_i[w] < ref_age)
            ages_o[w] = ages_i[w] + age_t'(1);
        end
      end
    end else if (fill_i) begin
      // empty ways are never aged, so they cannot wrap
      for (int w = 0; w < int'(WAYS); w++) begin
        if (way_t'(w) == fill_way_i)
          ages_o[w] = '0;
        else if (occ_i[w])
          ages_o[w] = ages_i[w] + age_t'(1);
      end
      occ_o[fill_way_i] = 1'b1;
    end
  end
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
  import lru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 8,
  localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      set_i,
  input  logic                  hit_i,
  input  logic [WAY_W-1:0]      hit_way_i,
  input  logic                  fill_i,
  output logic [WAY_W-1:0]      victim_o,
  output logic                  full_o,
  output logic [WAYS-1:0]       occ_o,
  output logic [WAYS*AGE_W-1:0] ages_o
);
  age_vec_t age_q [NUM_SETS];
  occ_t     occ_q [NUM_SETS];

  age_vec_t sel_ages, nxt_ages;
  occ_t     sel_occ, nxt_occ;
  way_t     fill_way;
  logic     sel_full;

  assign sel_ages = age_q[set_i];
  assign sel_occ  = occ_q[set_i];

  lru_victim_pick u_pick (
    .ages_i (sel_ages),
    .occ_i  (sel_occ),
    .way_o  (fill_way),
    .full_o (sel_full)
  );

  lru_age_next u_next (
    .ages_i     (sel_ages),
    .occ_i      (sel_occ),
    .hit_i      (hit_i),
    .hit_way_i  (hit_way_i),
    .fill_i     (fill_i),
    .fill_way_i (fill_way),
    .ages_o     (nxt_ages),
    .occ_o      (nxt_occ)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(NUM_SETS); s++) begin
        age_q[s] <= '0;
        occ_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < int'(NUM_SETS); s++) begin
        if (set_i == IDX_W'(s)) begin
          age_q[s] <= nxt_ages;
          occ_q[s] <= nxt_occ;
        end
      end
    end
  end

  assign victim_o = fill_way;
  assign full_o   = sel_full;
  assign occ_o    = sel_occ;
  assign ages_o   = sel_ages;

  function automatic logic ages_distinct(age_vec_t a, occ_t o);
    for (int i = 0; i < int'(WAYS); i++)
      for (int j = i + 1; j < int'(WAYS); j++)
        if (o[i] && o[j] && a[i] == a[j]) return 1'b0;
    return 1'b1;
  endfunction

  // R7
  ages_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ages_distinct(sel_ages, sel_occ));

  // R2
  hit_youngest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && sel_occ[hit_way_i] |=> age_q[$past(set_i)][$past(hit_way_i)] == '0);

  // R3
  hit_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !sel_occ[hit_way_i] |=>
      age_q[$past(set_i)] == $past(sel_ages) && occ_q[$past(set_i)] == $past(sel_occ));

  // R4
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !hit_i |=>
      occ_q[$past(set_i)][$past(victim_o)] && age_q[$past(set_i)][$past(victim_o)] == '0);

  // R5
  full_victim_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> sel_ages[victim_o] == AGE_OLDEST);

  // R8
  hit_beats_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && fill_i |=> $countones(occ_q[$past(set_i)]) == $past($countones(sel_occ)));
endmodule

// File: tb/tb_lru_age_tracker.sv
module tb_lru_age_tracker;
  localparam int NSETS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] set_i = '0;
  logic       hit = 1'b0;
  logic [1:0] hit_way = '0;
  logic       fill = 1'b0;
  logic [1:0] victim;
  logic       full;
  logic [3:0] occ;
  logic [7:0] ages;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lru_age_tracker #(.NUM_SETS(NSETS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_i), .hit_i(hit), .hit_way_i(hit_way),
    .fill_i(fill), .victim_o(victim), .full_o(full), .occ_o(occ), .ages_o(ages)
  );

  // reference: recency list per set, most recent first
  int ord [NSETS][4];
  int cnt [NSETS];

  typedef struct packed {
    logic       h;
    logic       f;
    logic [1:0] w;
    logic [2:0] s;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd0, 3'd0}, '{1'b0, 1'b1, 2'd0, 3'd0},
    '{1'b1, 1'b0, 2'd0, 3'd0}, '{1'b0, 1'b1, 2'd0, 3'd0},
    '{1'b0, 1'b1, 2'd0, 3'd0}, '{1'b1, 1'b0, 2'd2, 3'd0},
    '{1'b1, 1'b0, 2'd0, 3'd0}, '{1'b0, 1'b1, 2'd0, 3'd0},
    '{1'b1, 1'b0, 2'd3, 3'd0}, '{1'b0, 1'b1, 2'd0, 3'd0},
    '{1'b1, 1'b0, 2'd3, 3'd0}, '{1'b0, 1'b1, 2'd0, 3'd5},
    '{1'b0, 1'b1, 2'd0, 3'd5}, '{1'b1, 1'b0, 2'd3, 3'd5},
    '{1'b1, 1'b0, 2'd0, 3'd5}, '{1'b1, 1'b1, 2'd1, 3'd5},
    '{1'b0, 1'b1, 2'd0, 3'd5}, '{1'b1, 1'b1, 2'd2, 3'd5},
    '{1'b0, 1'b1, 2'd0, 3'd0}, '{1'b0, 1'b1, 2'd0, 3'd7}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pos_of(int s, int w);
    for (int i = 0; i < cnt[s]; i++) if (ord[s][i] == w) return i;
    return -1;
  endfunction

  function automatic int exp_victim(int s);
    if (cnt[s] == 4) return ord[s][3];
    for (int w = 0; w < 4; w++) if (pos_of(s, w) < 0) return w;
    return 0;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++) begin
      cnt[s] = 0;
      for (int i = 0; i < 4; i++) ord[s][i] = 0;
    end
  endtask

  task automatic model_apply(input logic h, input logic f, input int w, input int s);
    int p;
    int v;
    if (h) begin
      p = pos_of(s, w);
      if (p >= 0) begin
        for (int i = p; i > 0; i--) ord[s][i] = ord[s][i-1];
        ord[s][0] = w;
      end
    end else if (f) begin
      v = exp_victim(s);
      if (cnt[s] < 4) begin
        for (int i = cnt[s]; i > 0; i--) ord[s][i] = ord[s][i-1];
        cnt[s]++;
      end else begin
        for (int i = 3; i > 0; i--) ord[s][i] = ord[s][i-1];
      end
      ord[s][0] = v;
    end
  endtask

  // compare outputs of set s against the model; caller is away from the edge
  task automatic check_set(input int s, input string tag);
    int p;
    int exp_occ;
    set_i = 3'(s);
    #1;
    exp_occ = 0;
    for (int w = 0; w < 4; w++) if (pos_of(s, w) >= 0) exp_occ |= (1 << w);
    check(occ == 4'(exp_occ), tag, occ, exp_occ);
    for (int w = 0; w < 4; w++) begin
      p = pos_of(s, w);
      if (p < 0) p = 0;
      check(int'(ages[2*w +: 2]) == p, tag, ages[2*w +: 2], p);
    end
    check(full == (cnt[s] == 4), "R6 full", full, cnt[s] == 4);
    check(int'(victim) == exp_victim(s), "R6 victim", victim, exp_victim(s));
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (occ[i] && occ[j])
          check(ages[2*i +: 2] != ages[2*j +: 2], "R7 distinct", ages[2*i +: 2], -1);
  endtask

  task automatic do_op(input logic h, input logic f, input logic [1:0] w, input logic [2:0] s);
    string tag;
    if (h && f)                            tag = "R8 hit+fill";
    else if (h && pos_of(int'(s), int'(w)) < 0) tag = "R3 empty hit";
    else if (h)                            tag = "R2 hit";
    else if (f && cnt[s] == 4)             tag = "R5 full fill";
    else                                   tag = "R4 fill";
    @(negedge clk);
    set_i = s; hit = h; fill = f; hit_way = w;
    #1;
    check(int'(victim) == exp_victim(int'(s)), "R6 victim before op", victim, exp_victim(int'(s)));
    @(posedge clk);
    @(negedge clk);
    hit = 1'b0; fill = 1'b0;
    model_apply(h, f, int'(w), int'(s));
    check_set(int'(s), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    // R1: reset state of every set
    for (int s = 0; s < NSETS; s++) check_set(s, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) do_op(VECS[k].h, VECS[k].f, VECS[k].w, VECS[k].s);

    // R9: every set, touched or not, matches the model
    for (int s = 0; s < NSETS; s++) check_set(s, "R9 set isolation");

    // R5: repeated full-set replacement walks through all ways
    for (int k = 0; k < 5; k++) do_op(1'b0, 1'b1, 2'd0, 3'd0);
    // R2: hit on the oldest way
    do_op(1'b1, 1'b0, 2'(ord[0][3]), 3'd0);
    // R8: hit+fill on a full set keeps occupancy, moves the hit way
    do_op(1'b1, 1'b1, 2'(ord[0][2]), 3'd0);
    // R3: hit on an empty way of a partly filled set
    do_op(1'b1, 1'b0, 2'd3, 3'd7);
    check_set(5, "R9 set isolation");

    // R1: asynchronous reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    for (int s = 0; s < NSETS; s++) check_set(s, "R1 reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    do_op(1'b0, 1'b1, 2'd0, 3'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule